// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM with 1024 rows out of power-up and keeps it refreshed afterwards. First it waits out a power-up pause, counted in clock cycles. It then runs a burst of back-to-back CAS-before-RAS (CBR) cycles. Only after that burst does it declare the memory ready. From then on an interval timer requests one CBR cycle per refresh interval. The bus is shared with an access controller, so the block asks for it through `bus_req`/`bus_gnt`. It drives the row strobe and both byte column strobes only while it holds the bus. In a CBR cycle the device supplies the row itself, so no address is produced.

Self refresh is optional. A request to enter it is honoured only once every row has been refreshed since the last exit (or since power-up). Entry begins with one ordinary CBR cycle, directly followed by a CBR-style entry in which RAS is held low for at least the self-refresh minimum. The block leaves self refresh when the exit input is high. It then applies the longer self-refresh precharge and immediately runs one more CBR cycle. Ordinary CBR pulses are far shorter than the self-refresh minimum, so RAS is never held low for a length in the forbidden band between the two.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While `rst` is high: `ras_n`=1, `cas_n`=2'b11, `bus_req`=0, `init_done`=0, `overdue`=0, `sr_active`=0, `sr_ok`=0.
- R2: After reset is released, `bus_req` first goes high in the PAUSE_CYC-th cycle, and no strobe moves before it.
- R3: Both bits of `cas_n` always move together. Before each RAS falling edge they have been low for at least T_CSR cycles, and they stay low for as long as RAS is low.
- R4: An ordinary refresh holds RAS low for exactly T_RAS cycles. A self-refresh pulse holds it low for at least T_SR_MIN cycles. No other RAS-low length occurs.
- R5: Between two ordinary pulses, RAS stays high for at least T_RP+T_CSR cycles. CAS stays high for at least T_RP cycles before it falls again.
- R6: `init_done` rises only after exactly INIT_CYCLES CBR cycles have completed, and it then stays high.
- R7: Once initialisation is done, and with the grant held high and no self refresh, successive distributed refresh RAS falls are exactly INTERVAL_CYC cycles apart.
- R8: The block holds `bus_req` high whenever it drives a strobe active. While `bus_gnt` is low and no sequence has started, it keeps `bus_req` high and leaves the strobes inactive.
- R9: `overdue` rises when a refresh interval elapses while a refresh is still pending. It falls on the cycle in which that pending refresh is granted.
- R10: With `sr_req` high and `sr_ok` high, an ordinary CBR cycle is followed immediately by the self-refresh pulse. Its RAS falls T_RAS+T_RP+T_CSR cycles after the preceding fall. `sr_active` is high while RAS is held, and RAS is held until `sr_exit` is high.
- R11: After self refresh, RAS stays high for exactly T_RPS+T_CSR cycles before the next CBR cycle falls.
- R12: `sr_ok` is low right after a self-refresh exit. It rises once ROWS CBR cycles have completed since that exit. With `sr_req` held high, exactly ROWS+1 ordinary pulses separate two self-refresh pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| sr_req | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Allow leaving self refresh |
| bus_gnt | input | 1 | Bus granted by the access controller |
| bus_req | output | 1 | Bus wanted or held by the sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Upper and lower column strobes, active low |
| init_done | output | 1 | Initialisation finished, normal access allowed |
| sr_active | output | 1 | Device is held in self refresh |
| sr_ok | output | 1 | All rows refreshed since the last exit |
| overdue | output | 1 | A pending refresh has waited a full interval |

## Verification
Each output is decoded straight from registered state, so every result appears in the cycle after the edge that changes that state. For example, `bus_req` first shows in cycle PAUSE_CYC. `overdue` clears one edge after the grant arrives. A self-refresh RAS fall lands T_RAS+T_RP+T_CSR cycles after the fall before it, and the post-exit fall comes T_RPS+T_CSR cycles after RAS rises. The bench samples on the falling clock edge and measures every low and high run in whole cycles. It compares each run length and fall-to-fall gap against these sums exactly, with a lower bound only where the requirement itself gives one.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_CSET,
        ST_RASLO,
        ST_PRE,
        ST_SRPRE
    } seq_state_t;

    // purpose of the CBR cycle in progress
    typedef enum logic [1:0] {
        JOB_INIT,
        JOB_DIST,
        JOB_PRE_SR,
        JOB_SR
    } job_t;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;
    } strobe_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic start,
    output logic pending,
    output logic overdue
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = run && (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt    <= '0;
            pending <= 1'b0;
            overdue <= 1'b0;
        end else begin
            if (!run || tcnt == LAST) tcnt <= '0;
            else                      tcnt <= tcnt + 1'b1;

            if (tick)       pending <= 1'b1;
            else if (start) pending <= 1'b0;

            if (start)                overdue <= 1'b0;
            else if (tick && pending) overdue <= 1'b1;
        end
    end

    // R9: an overdue refresh is always still pending
    assert_overdue_pending_R9: assert property (@(posedge clk) disable iff (rst)
        overdue |-> pending);

    // R9: a grant clears the overdue flag on the next cycle
    assert_overdue_clear_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !overdue);

endmodule

// File: rtl/drs_row_tracker.sv
module drs_row_tracker #(
    parameter int ROWS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic init_done,
    input  logic cbr_done,
    input  logic sr_leave,
    output logic sr_ok
);
    localparam int RW = $clog2(ROWS + 1);
    localparam logic [RW-1:0] FULL = RW'(ROWS);

    logic [RW-1:0] rows;

    always_ff @(posedge clk) begin
        if (rst || sr_leave)             rows <= '0;
        else if (cbr_done && rows != FULL) rows <= rows + 1'b1;
    end

    assign sr_ok = init_done && (rows == FULL);

    // R12: sr_ok only rises as a refresh completes or init finishes
    assert_ok_rise_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_ok) |-> ($past(cbr_done) || $rose(init_done)));

    // R12: leaving self refresh withdraws permission
    assert_ok_drop_R12: assert property (@(posedge clk) disable iff (rst)
        sr_leave |=> !sr_ok);

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
    import drs_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int ROWS         = 1024,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 4,
    parameter int T_RPS        = 11,
    parameter int T_SR_MIN     = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sr_req,
    input  logic       sr_exit,
    input  logic       bus_gnt,
    output logic       bus_req,
    output logic       ras_n,
    output logic [1:0] cas_n,
    output logic       init_done,
    output logic       sr_active,
    output logic       sr_ok,
    output logic       overdue
);
    localparam int MAXD = max2(max2(PAUSE_CYC, T_SR_MIN),
                               max2(max2(T_RAS, T_RP), max2(T_RPS, T_CSR)));
    localparam int CW = $clog2(MAXD + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam int LW = $clog2(T_SR_MIN + 1);

    localparam logic [CW-1:0] C_PAUSE = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] C_CSR   = CW'(T_CSR - 1);
    localparam logic [CW-1:0] C_RAS   = CW'(T_RAS - 1);
    localparam logic [CW-1:0] C_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] C_RPS   = CW'(T_RPS - 1);
    localparam logic [CW-1:0] C_SRMIN = CW'(T_SR_MIN - 1);
    localparam logic [IW-1:0] C_INIT  = IW'(INIT_CYCLES - 1);

    seq_state_t    state;
    job_t          job;
    logic [CW-1:0] cnt;
    logic [IW-1:0] init_cnt;
    strobe_t       strb;
    logic          pending, start, cbr_done, sr_leave, sr_block;

    assign start    = (state == ST_REQ) && bus_gnt;
    assign cbr_done = (state == ST_PRE) && (cnt == C_RP);
    assign sr_leave = (state == ST_RASLO) && (job == JOB_SR) && sr_exit && (cnt >= C_SRMIN);
    assign sr_block = (state == ST_SRPRE) ||
                      ((job == JOB_SR) && (state == ST_CSET || state == ST_RASLO));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PAUSE;
            job       <= JOB_INIT;
            cnt       <= '0;
            init_cnt  <= '0;
            init_done <= 1'b0;
        end else begin
            unique case (state)
                ST_PAUSE: begin
                    if (cnt == C_PAUSE) begin
                        state <= ST_REQ;
                        cnt   <= '0;
                        job   <= JOB_INIT;
                    end else cnt <= cnt + 1'b1;
                end
                ST_IDLE: begin
                    if (sr_req && sr_ok) begin
                        state <= ST_REQ;
                        job   <= JOB_PRE_SR;
                    end else if (pending) begin
                        state <= ST_REQ;
                        job   <= JOB_DIST;
                    end
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        state <= ST_CSET;
                        cnt   <= '0;
                    end
                end
                ST_CSET: begin
                    if (cnt == C_CSR) begin
                        state <= ST_RASLO;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_RASLO: begin
                    if (job == JOB_SR) begin
                        if (sr_leave) begin
                            state <= ST_SRPRE;
                            cnt   <= '0;
                        end else if (cnt < C_SRMIN) cnt <= cnt + 1'b1;
                    end else if (cnt == C_RAS) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_PRE: begin
                    if (cnt == C_RP) begin
                        cnt <= '0;
                        case (job)
                            JOB_INIT: begin
                                init_cnt <= init_cnt + 1'b1;
                                if (init_cnt == C_INIT) begin
                                    state     <= ST_IDLE;
                                    init_done <= 1'b1;
                                end else state <= ST_CSET;
                            end
                            JOB_PRE_SR: begin
                                job   <= JOB_SR;
                                state <= ST_CSET;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end else cnt <= cnt + 1'b1;
                end
                ST_SRPRE: begin
                    if (cnt == C_RPS) begin
                        state <= ST_CSET;
                        job   <= JOB_DIST;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_PAUSE;
            endcase
        end
    end

    always_comb begin
        strb = '{ras_n: 1'b1, cas_n: 2'b11};
        if (state == ST_CSET)  strb.cas_n = 2'b00;
        if (state == ST_RASLO) strb = '{ras_n: 1'b0, cas_n: 2'b00};
    end

    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;
    assign bus_req   = (state != ST_PAUSE) && (state != ST_IDLE);
    assign sr_active = (state == ST_RASLO) && (job == JOB_SR);

    drs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (init_done && !sr_block),
        .start   (start),
        .pending (pending),
        .overdue (overdue)
    );

    drs_row_tracker #(.ROWS(ROWS)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .init_done (init_done),
        .cbr_done  (cbr_done),
        .sr_leave  (sr_leave),
        .sr_ok     (sr_ok)
    );

    // RAS-low run length, kept for the pulse-width property
    logic [LW-1:0] low_len;
    always_ff @(posedge clk) begin
        if (rst || ras_n)                low_len <= '0;
        else if (low_len != LW'(T_SR_MIN)) low_len <= low_len + 1'b1;
    end

    // R3: CAS is already low in the cycle before RAS falls
    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (cas_n == 2'b00 && $past(cas_n) == 2'b00));

    // R4: RAS-low length is the refresh width or at least the self-refresh minimum
    assert_ras_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_len == LW'(T_RAS) || low_len == LW'(T_SR_MIN)));

    // R8: strobes move only while the bus is held
    assert_strobe_owns_bus_R8: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || cas_n != 2'b11) |-> bus_req);

    // R6: ready stays ready
    assert_init_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R10: self refresh is entered only with permission
    assert_sr_gated_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_active) |-> sr_ok);

endmodule

// File: tb/dram_refresh_sequencer_test.sv
module dram_refresh_sequencer_test;
    localparam int PAUSE_CYC    = 20;
    localparam int INIT_CYCLES  = 8;
    localparam int INTERVAL_CYC = 60;
    localparam int ROWS         = 12;
    localparam int T_CSR        = 1;
    localparam int T_RAS        = 3;
    localparam int T_RP         = 2;
    localparam int T_RPS        = 5;
    localparam int T_SR_MIN     = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sr_req = 1'b0, sr_exit = 1'b1, bus_gnt = 1'b1;
    logic       bus_req, ras_n, init_done, sr_active, sr_ok, overdue;
    logic [1:0] cas_n;

    always #2 clk = ~clk;

    dram_refresh_sequencer #(
        .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES), .INTERVAL_CYC(INTERVAL_CYC),
        .ROWS(ROWS), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RPS(T_RPS),
        .T_SR_MIN(T_SR_MIN)
    ) uut (
        .clk(clk), .rst(rst), .sr_req(sr_req), .sr_exit(sr_exit), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done),
        .sr_active(sr_active), .sr_ok(sr_ok), .overdue(overdue)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: run lengths measured in sampled cycles
    int cyc = 0, rlow = 0, rhigh = 0, clow = 0, chigh = 0;
    int falls = 0, last_fall = 0, prev_fall = 0, sr_cnt = 0, norm_since = 0;
    bit rprev = 1, cprev = 1, after_sr = 0, seen_rise = 0, seen_cfall = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (cas_n == 2'b01 || cas_n == 2'b10)
                chk(0, "R3 cas split", cas_n, 0);
            if (!ras_n && cas_n != 2'b00)
                chk(0, "R3 cas high under ras", cas_n, 0);
            if (rprev && !ras_n) begin
                chk(cas_n == 2'b00 && clow >= T_CSR, "R3 cas setup", clow, T_CSR);
                chk(bus_req, "R8 req while driving", bus_req, 1);
                if (after_sr)
                    chk(rhigh == T_RPS + T_CSR, "R11 post-exit gap", rhigh, T_RPS + T_CSR);
                else if (seen_rise)
                    chk(rhigh >= T_RP + T_CSR, "R5 ras precharge", rhigh, T_RP + T_CSR);
                prev_fall = last_fall;
                last_fall = cyc;
                falls++;
            end
            if (!rprev && ras_n) begin
                seen_rise = 1;
                if (rlow == T_RAS) begin
                    norm_since++;
                    after_sr = 0;
                end else if (rlow >= T_SR_MIN) begin
                    chk(last_fall - prev_fall == T_RAS + T_RP + T_CSR, "R10 entry gap",
                        last_fall - prev_fall, T_RAS + T_RP + T_CSR);
                    if (sr_cnt > 0)
                        chk(norm_since == ROWS + 1, "R12 pulses between", norm_since, ROWS + 1);
                    sr_cnt++;
                    norm_since = 0;
                    after_sr = 1;
                end else begin
                    chk(0, "R4 ras width", rlow, T_RAS);
                end
            end
            if (cprev && cas_n == 2'b00) begin
                if (seen_cfall) chk(chigh >= T_RP, "R5 cas precharge", chigh, T_RP);
                seen_cfall = 1;
            end
            if (ras_n) begin rhigh++; rlow = 0; end else begin rlow++; rhigh = 0; end
            if (cas_n == 2'b11) begin chigh++; clow = 0; end else begin clow++; chigh = 0; end
            rprev = ras_n;
            cprev = (cas_n == 2'b11);
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    initial begin
        int t_prev, gap, f0;
        repeat (4) tick();
        chk(ras_n == 1 && cas_n == 2'b11, "R1 strobes", {ras_n, cas_n}, 7);
        chk(!bus_req && !init_done && !overdue && !sr_active && !sr_ok, "R1 flags",
            {bus_req, init_done, overdue, sr_active, sr_ok}, 0);
        rst = 1'b0;
        while (!bus_req) tick();
        chk(cyc == PAUSE_CYC, "R2 pause length", cyc, PAUSE_CYC);
        chk(falls == 0 && ras_n && cas_n == 2'b11, "R2 quiet pause", falls, 0);
        while (!init_done) tick();
        chk(falls == INIT_CYCLES, "R6 init count", falls, INIT_CYCLES);
        chk(!sr_ok, "R12 ok before all rows", sr_ok, 0);
        // distributed refresh spacing
        f0 = falls;
        while (falls == f0) tick();
        t_prev = last_fall;
        for (int k = 0; k < 3; k++) begin
            f0 = falls;
            while (falls == f0) tick();
            gap = last_fall - t_prev;
            chk(gap == INTERVAL_CYC, "R7 interval", gap, INTERVAL_CYC);
            t_prev = last_fall;
        end
        chk(init_done, "R6 sticky", init_done, 1);
        chk(!overdue, "R9 no overdue when granted", overdue, 0);
        // self refresh, early exit allowed
        sr_req = 1'b1;
        while (sr_cnt == 0) tick();
        chk(!sr_ok, "R12 ok dropped after exit", sr_ok, 1'b0);
        // second entry, exit held back
        sr_exit = 1'b0;
        while (!sr_active) tick();
        repeat (50) tick();
        chk(sr_active && !ras_n, "R10 held until exit", {sr_active, ras_n}, 2);
        sr_exit = 1'b1;
        while (sr_cnt < 2) tick();
        sr_req = 1'b0;
        // grant withheld
        while (bus_req) tick();
        bus_gnt = 1'b0;
        f0 = falls;
        repeat (2 * INTERVAL_CYC + 10) tick();
        chk(overdue, "R9 overdue raised", overdue, 1);
        chk(bus_req && ras_n && cas_n == 2'b11 && falls == f0, "R8 wait for grant",
            falls - f0, 0);
        bus_gnt = 1'b1;
        repeat (2) tick();
        chk(!overdue, "R9 overdue cleared", overdue, 0);
        repeat (10) tick();
        chk(falls > f0, "R8 refresh after grant", falls - f0, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 30000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule